// File: doc/BRIEF.md
# Six-Motor Attitude Mixer

This block turns four normalized flight commands (roll, pitch, yaw and thrust) into six motor power words. Each motor owns a row of three signed mixing coefficients. The block forms the dot product of that row with the centered roll/pitch/yaw offsets, adds unity, and multiplies the resulting gain by thrust. The product is clamped into the unsigned 16-bit output range.

A single multiplier is shared across all the work. Each motor takes three accumulate steps and one scaling step, so one command produces a fresh set of six powers after a fixed latency, and a one-cycle valid strobe marks the update. A kill input bypasses the datapath and forces every output word to zero at once. Releasing kill brings back the last computed powers. Coefficients are loaded through a plain address/data write port.

Top module: `hexa_mixer`

## Requirements
- R1: After reset every output word is 0, out_valid_o is low and all 18 coefficients are 0.
- R2: A write with cfg_we_i high stores cfg_data_i, a signed Q1.14 coefficient, at address motor*3 + axis, where axis 0 is roll, 1 is pitch and 2 is yaw. Writes to addresses 18 and above change nothing.
- R3: Commands are unsigned Q0.16. Roll, pitch and yaw are turned into signed offsets s = cmd − 0x8000. Thrust is used unsigned.
- R4: Motor m's power is floor(thrust·(2^29 + Σa c[m][a]·s[a]) / 2^29) when that value lies in [0, 0xFFFF].
- R5: A power formula result above 0xFFFF is output as 0xFFFF.
- R6: A negative power formula result is output as 0.
- R7: out_valid_o pulses high for exactly one cycle, 24 clock cycles after the edge that accepts cmd_valid_i. The new powers appear in the same cycle.
- R8: cmd_valid_i is ignored while a computation is in progress. No extra result is produced and the running result is not altered.
- R9: While kill_i is high every output word is 0 without waiting for a clock edge. The computation continues, and the registered powers show again once kill_i falls.
- R10: Output words hold their value between valid pulses while kill_i stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Start strobe for a new command set |
| roll_i | input | 16 | Roll command, unsigned Q0.16 |
| pitch_i | input | 16 | Pitch command, unsigned Q0.16 |
| yaw_i | input | 16 | Yaw command, unsigned Q0.16 |
| thrust_i | input | 16 | Thrust command, unsigned Q0.16 |
| cfg_we_i | input | 1 | Coefficient write enable |
| cfg_addr_i | input | 5 | Coefficient address, motor*3 + axis |
| cfg_data_i | input | 16 | Coefficient value, signed Q1.14 |
| kill_i | input | 1 | Forces all outputs to zero |
| out_valid_o | output | 1 | One-cycle strobe when new powers are presented |
| motor_pwr_o | output | 96 | Six powers; motor m at bits [16m+15:16m] |

## Verification
A stale accumulator or a misrouted coefficient shows up at the next valid pulse as one or more motor words that differ from the formula. The error is confined to the motors whose rows were touched. A sequencer that loses its place shows up as a valid pulse off the 24-cycle mark, a missing or double pulse, or output words that move between pulses. Kill faults are visible in the same cycle, because the gating is combinational on the outputs.

// File: rtl/hexmix_pkg.sv
package hexmix_pkg;
   typedef enum logic [1:0] {
      AX_ROLL  = 2'd0,
      AX_PITCH = 2'd1,
      AX_YAW   = 2'd2,
      AX_SCALE = 2'd3
   } mix_step_e;

   function automatic int unsigned step_count(input int unsigned axes);
      return axes + 1;
   endfunction
endpackage

// File: rtl/hexmix_coef_rf.sv
module hexmix_coef_rf #(
   parameter int NUM_MOTORS = 6,
   parameter int NUM_AXES   = 3,
   parameter int COEF_W     = 16,
   parameter int ADDR_W     = 5,
   parameter int MOT_W      = 3,
   parameter int STEP_W     = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic signed [COEF_W-1:0] data_i,
   input  logic [MOT_W-1:0]         rd_motor_i,
   input  logic [STEP_W-1:0]        rd_axis_i,
   output logic signed [COEF_W-1:0] rd_coef_o
);
   logic signed [COEF_W-1:0] mem_q [NUM_MOTORS][NUM_AXES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int m = 0; m < NUM_MOTORS; m++)
            for (int a = 0; a < NUM_AXES; a++)
               mem_q[m][a] <= '0;
      end else if (we_i) begin
         for (int m = 0; m < NUM_MOTORS; m++)
            for (int a = 0; a < NUM_AXES; a++)
               if (addr_i == ADDR_W'(m * NUM_AXES + a))
                  mem_q[m][a] <= data_i;
      end
   end

   always_comb begin
      rd_coef_o = '0;
      for (int m = 0; m < NUM_MOTORS; m++)
         for (int a = 0; a < NUM_AXES; a++)
            if (rd_motor_i == MOT_W'(m) && rd_axis_i == STEP_W'(a))
               rd_coef_o = mem_q[m][a];
   end
endmodule

// File: rtl/hexmix_seq.sv
module hexmix_seq #(
   parameter int NUM_MOTORS = 6,
   parameter int NUM_AXES   = 3,
   parameter int MOT_W      = 3,
   parameter int STEP_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              accept_o,
   output logic              busy_o,
   output logic [MOT_W-1:0]  motor_o,
   output logic [STEP_W-1:0] step_o,
   output logic              first_o,
   output logic              scale_o,
   output logic              done_o
);
   localparam logic [MOT_W-1:0]  LAST_MOT   = MOT_W'(NUM_MOTORS - 1);
   localparam logic [STEP_W-1:0] SCALE_STEP = STEP_W'(NUM_AXES);

   logic              busy_q;
   logic [MOT_W-1:0]  motor_q;
   logic [STEP_W-1:0] step_q;

   assign accept_o = start_i && !busy_q;
   assign busy_o   = busy_q;
   assign motor_o  = motor_q;
   assign step_o   = step_q;
   assign first_o  = busy_q && (step_q == '0);
   assign scale_o  = busy_q && (step_q == SCALE_STEP);
   assign done_o   = scale_o && (motor_q == LAST_MOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         motor_q <= '0;
         step_q  <= '0;
      end else if (accept_o) begin
         busy_q  <= 1'b1;
         motor_q <= '0;
         step_q  <= '0;
      end else if (busy_q) begin
         if (step_q == SCALE_STEP) begin
            step_q <= '0;
            if (motor_q == LAST_MOT) busy_q  <= 1'b0;
            else                     motor_q <= motor_q + 1'b1;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hexmix_mac.sv
module hexmix_mac #(
   parameter int CMD_W    = 16,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 36,
   parameter int SHIFT    = 29,
   parameter bit SATURATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic                     first_i,
   input  logic                     scale_i,
   input  logic signed [COEF_W-1:0] coef_i,
   input  logic signed [CMD_W:0]    off_i,
   input  logic [CMD_W-1:0]         thrust_i,
   output logic [CMD_W-1:0]         res_o
);
   localparam int PROD_W = CMD_W + 1 + ACC_W;
   localparam logic signed [ACC_W-1:0]  ONE_ACC = {{(ACC_W-1){1'b0}}, 1'b1} << SHIFT;
   localparam logic signed [PROD_W-1:0] MAX_OUT = {{(PROD_W-CMD_W){1'b0}}, {CMD_W{1'b1}}};

   logic signed [ACC_W-1:0]  acc_q;
   logic signed [CMD_W:0]    mul_a;
   logic signed [ACC_W-1:0]  mul_b;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_lo;
   logic signed [PROD_W-1:0] shifted;

   always_comb begin
      if (scale_i) begin
         mul_a = {1'b0, thrust_i};
         mul_b = acc_q;
      end else begin
         mul_a = off_i;
         mul_b = {{(ACC_W-COEF_W){coef_i[COEF_W-1]}}, coef_i};
      end
   end

   assign prod    = mul_a * mul_b;
   assign prod_lo = prod[ACC_W-1:0];
   assign shifted = prod >>> SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_q <= '0;
      else if (en_i && !scale_i) acc_q <= (first_i ? ONE_ACC : acc_q) + prod_lo;
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (shifted < 0)            res_o = '0;
            else if (shifted > MAX_OUT) res_o = '1;
            else                        res_o = shifted[CMD_W-1:0];
         end
      end else begin : g_wrap
         assign res_o = shifted[CMD_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/hexa_mixer.sv
module hexa_mixer #(
   parameter int CMD_W      = 16,
   parameter int COEF_W     = 16,
   parameter int COEF_FRAC  = 14,
   parameter int NUM_MOTORS = 6,
   parameter int NUM_AXES   = 3,
   parameter int ADDR_W     = 5,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid_i,
   input  logic [CMD_W-1:0]            roll_i,
   input  logic [CMD_W-1:0]            pitch_i,
   input  logic [CMD_W-1:0]            yaw_i,
   input  logic [CMD_W-1:0]            thrust_i,
   input  logic                        cfg_we_i,
   input  logic [ADDR_W-1:0]           cfg_addr_i,
   input  logic [COEF_W-1:0]           cfg_data_i,
   input  logic                        kill_i,
   output logic                        out_valid_o,
   output logic [NUM_MOTORS*CMD_W-1:0] motor_pwr_o
);
   localparam int MOT_W  = (NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1;
   localparam int STEP_W = $clog2(hexmix_pkg::step_count(NUM_AXES));
   localparam int SHIFT  = (CMD_W - 1) + COEF_FRAC;
   localparam int ACC_W  = CMD_W + COEF_W + $clog2(NUM_AXES) + 2;
   localparam logic signed [CMD_W:0] CENTER = {2'b01, {(CMD_W-1){1'b0}}};

   generate
      if (NUM_AXES != 3) begin : g_bad_axes
         $error("hexa_mixer: exactly three attitude axes are supported");
      end
      if (COEF_FRAC >= COEF_W) begin : g_bad_frac
         $error("hexa_mixer: COEF_FRAC must be below COEF_W");
      end
      if ((1 << ADDR_W) < NUM_MOTORS * NUM_AXES) begin : g_bad_addr
         $error("hexa_mixer: ADDR_W too narrow for the coefficient file");
      end
      if (NUM_MOTORS < 2) begin : g_bad_mot
         $error("hexa_mixer: NUM_MOTORS must be at least 2");
      end
   endgenerate

   logic              accept, busy, first, scale, done;
   logic [MOT_W-1:0]  motor;
   logic [STEP_W-1:0] step;
   logic signed [COEF_W-1:0] coef;
   logic signed [CMD_W:0]    off_q [NUM_AXES];
   logic signed [CMD_W:0]    off_sel;
   logic [CMD_W-1:0]         cmd_in [NUM_AXES];
   logic [CMD_W-1:0]         thr_q;
   logic [CMD_W-1:0]         res;
   logic [CMD_W-1:0]         work_q [NUM_MOTORS-1];
   logic [CMD_W-1:0]         pwr_q  [NUM_MOTORS];
   logic                     valid_q;

   assign cmd_in[0] = roll_i;
   assign cmd_in[1] = pitch_i;
   assign cmd_in[2] = yaw_i;

   hexmix_seq #(
      .NUM_MOTORS(NUM_MOTORS), .NUM_AXES(NUM_AXES), .MOT_W(MOT_W), .STEP_W(STEP_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(cmd_valid_i), .accept_o(accept),
      .busy_o(busy), .motor_o(motor), .step_o(step), .first_o(first),
      .scale_o(scale), .done_o(done)
   );

   hexmix_coef_rf #(
      .NUM_MOTORS(NUM_MOTORS), .NUM_AXES(NUM_AXES), .COEF_W(COEF_W),
      .ADDR_W(ADDR_W), .MOT_W(MOT_W), .STEP_W(STEP_W)
   ) rf_i (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
      .data_i(cfg_data_i), .rd_motor_i(motor), .rd_axis_i(step), .rd_coef_o(coef)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_AXES; a++) off_q[a] <= '0;
         thr_q <= '0;
      end else if (accept) begin
         for (int a = 0; a < NUM_AXES; a++) off_q[a] <= $signed({1'b0, cmd_in[a]}) - CENTER;
         thr_q <= thrust_i;
      end
   end

   always_comb begin
      off_sel = '0;
      for (int a = 0; a < NUM_AXES; a++)
         if (step == STEP_W'(a)) off_sel = off_q[a];
   end

   hexmix_mac #(
      .CMD_W(CMD_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT), .SATURATE(SATURATE)
   ) mac_i (
      .clk(clk), .rst_n(rst_n), .en_i(busy), .first_i(first), .scale_i(scale),
      .coef_i(coef), .off_i(off_sel), .thrust_i(thr_q), .res_o(res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int m = 0; m < NUM_MOTORS - 1; m++) work_q[m] <= '0;
         for (int m = 0; m < NUM_MOTORS; m++)     pwr_q[m]  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= done;
         for (int m = 0; m < NUM_MOTORS - 1; m++)
            if (scale && motor == MOT_W'(m)) work_q[m] <= res;
         if (done) begin
            for (int m = 0; m < NUM_MOTORS - 1; m++) pwr_q[m] <= work_q[m];
            pwr_q[NUM_MOTORS-1] <= res;
         end
      end
   end

   assign out_valid_o = valid_q;

   generate
      for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_out
         assign motor_pwr_o[m*CMD_W +: CMD_W] = kill_i ? '0 : pwr_q[m];
      end
   endgenerate
endmodule

// File: rtl/hexmix_chk.sv
module hexmix_chk #(
   parameter int CMD_W      = 16,
   parameter int NUM_MOTORS = 6,
   parameter int NUM_AXES   = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cmd_valid_i,
   input logic                        kill_i,
   input logic                        out_valid_o,
   input logic [NUM_MOTORS*CMD_W-1:0] motor_pwr_o
);
   localparam int LAT = NUM_MOTORS * (NUM_AXES + 1);

   logic     act_q;
   int       cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= 0;
      end else if (!act_q || cnt_q == LAT) begin
         act_q <= cmd_valid_i;
         cnt_q <= 0;
      end else begin
         cnt_q <= cnt_q + 1;
      end
   end

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |=> !out_valid_o);

   // R7
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (act_q && cnt_q == LAT));

   // R9
   kill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |-> (motor_pwr_o == '0));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid_o && !kill_i && !$past(kill_i)) |-> $stable(motor_pwr_o));
endmodule

bind hexa_mixer hexmix_chk #(
   .CMD_W(CMD_W), .NUM_MOTORS(NUM_MOTORS), .NUM_AXES(NUM_AXES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .kill_i(kill_i),
   .out_valid_o(out_valid_o), .motor_pwr_o(motor_pwr_o)
);

// File: tb/hexa_mixer_tb_top.sv
`timescale 1ns/1ps
module hexa_mixer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] roll = '0, pitch = '0, yaw = '0, thrust = '0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_data = '0;
   logic        kill = 1'b0;
   logic        out_valid;
   logic [95:0] pwr;

   int errors = 0, checks = 0, cyc = 0;
   int coef_m [6][3];
   logic [95:0] exp_q [$];
   int          iss_q [$];
   logic [95:0] last_exp = '0;
   bit          prev_v = 1'b0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hexa_mixer dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .roll_i(roll),
      .pitch_i(pitch), .yaw_i(yaw), .thrust_i(thrust), .cfg_we_i(cfg_we),
      .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data), .kill_i(kill),
      .out_valid_o(out_valid), .motor_pwr_o(pwr)
   );

   task automatic chk(string req, logic [95:0] act, logic [95:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [15:0] model(int m, int r, int p, int y, int t);
      longint acc, prod, q;
      acc = longint'(1) <<< 29;
      acc += longint'(coef_m[m][0]) * (longint'(r) - 32768);
      acc += longint'(coef_m[m][1]) * (longint'(p) - 32768);
      acc += longint'(coef_m[m][2]) * (longint'(y) - 32768);
      prod = longint'(t) * acc;
      q = prod >>> 29;
      if (q < 0) return 16'h0000;
      if (q > 65535) return 16'hFFFF;
      return 16'(q);
   endfunction

   task automatic write_coef(int m, int a, int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'(m * 3 + a); cfg_data = 16'(val);
      coef_m[m][a] = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_raw(int addr, int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_data = 16'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic issue(int r, int p, int y, int t);
      logic [95:0] e;
      for (int m = 0; m < 6; m++) e[m*16 +: 16] = model(m, r, p, y, t);
      @(negedge clk);
      exp_q.push_back(e);
      iss_q.push_back(cyc + 1);
      last_exp = e;
      roll = 16'(r); pitch = 16'(p); yaw = 16'(y); thrust = 16'(t);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor / scoreboard
   always begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
         if (prev_v) begin
            checks++; errors++;
            $display("FAIL R7: valid high two cycles, actual=1 expected=0");
         end
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8: unexpected result, actual=%h expected=none", pwr);
         end else begin
            logic [95:0] e;
            int          iss;
            e   = exp_q.pop_front();
            iss = iss_q.pop_front();
            if (kill) e = '0;
            for (int m = 0; m < 6; m++)
               chk("R4 motor power", {80'b0, pwr[m*16 +: 16]}, {80'b0, e[m*16 +: 16]});
            chk("R7 latency", 96'(cyc - iss), 96'(24));
         end
      end
      prev_v = out_valid;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int m = 0; m < 6; m++) for (int a = 0; a < 3; a++) coef_m[m][a] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", pwr, '0);
      chk("R1 reset valid", {95'b0, out_valid}, '0);
      rst_n = 1'b1;

      // R1 coefficients start at zero, R3 centered, R4 power equals thrust
      issue(16'h8000, 16'h8000, 16'h8000, 16'h4000);
      drain();
      chk("R1 R3 zero-coef result", pwr, {6{16'h4000}});
      issue(16'hFFFF, 16'h0000, 16'h1234, 16'hFFFF);
      drain();

      // R2 program a mixing pattern
      for (int m = 0; m < 6; m++) begin
         write_coef(m, 0, (m < 3) ? 4096 : -4096);
         write_coef(m, 1, ((m % 3) - 1) * 3072);
         write_coef(m, 2, (m % 2) ? 1536 : -1536);
      end
      issue(16'hA000, 16'h6000, 16'h9000, 16'h8000);
      drain();
      issue(16'h2000, 16'hE000, 16'h7000, 16'hC000);
      drain();

      // R10 hold between pulses
      repeat (10) @(negedge clk);
      chk("R10 hold", pwr, last_exp);

      // R2 out-of-range addresses ignored
      write_raw(18, 16'h7FFF);
      write_raw(31, 16'h8000);
      issue(16'hA000, 16'h6000, 16'h9000, 16'h8000);
      drain();

      // R5 / R6 clamping
      write_coef(0, 0, 32767);
      write_coef(1, 0, -32768);
      issue(16'hFFFF, 16'h8000, 16'h8000, 16'hC000);
      drain();
      chk("R5 clamp high", {80'b0, pwr[15:0]}, {80'b0, 16'hFFFF});
      chk("R6 clamp low", {80'b0, pwr[31:16]}, '0);

      // R8 command during computation ignored
      issue(16'h9000, 16'h7000, 16'h8800, 16'h6000);
      repeat (5) @(negedge clk);
      roll = 16'h0100; thrust = 16'hFFFF; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      drain();
      repeat (30) @(negedge clk);
      chk("R8 busy command ignored", pwr, last_exp);

      // R9 kill while idle, combinational
      kill = 1'b1;
      #1;
      chk("R9 kill immediate", pwr, '0);
      @(negedge clk);
      kill = 1'b0;
      #1;
      chk("R9 kill release", pwr, last_exp);

      // R9 kill during a computation
      issue(16'h4000, 16'hC000, 16'h8000, 16'hA000);
      repeat (4) @(negedge clk);
      kill = 1'b1;
      drain();
      chk("R9 kill during run", pwr, '0);
      kill = 1'b0;
      #1;
      chk("R9 result after kill", pwr, last_exp);

      repeat (3) @(negedge clk);
      chk("R7 no pending results", 96'(exp_q.size()), '0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule